// File: doc/BRIEF.md
# Binary Buddy Block Allocator

This block hands out and takes back pieces of a pool of 2^N equal minimum-size units. A piece always covers 2^k units for some order k between 0 and N and always starts on a unit index that is a multiple of 2^k. The pool is viewed as a binary tree. The root is the whole pool, and each node splits into a lower and an upper half. The allocator keeps one "free" bit and one "granted" bit for every node of that tree.

An allocation names an order. The allocator looks for the smallest free block of that order or larger. If several blocks of that order are free, it takes the one with the lowest start unit. It then halves the chosen block, keeping the lower half and leaving each upper half free, until the block has the requested order, and returns its start unit. A release names a start unit and an order. If that exact block is currently granted, the allocator marks it free. It then merges the block with its buddy, the block whose start unit differs only in bit k, and repeats the merge one order higher. This continues until a buddy is busy or the root is free again. Requests that cannot be served report a failure or an error and leave the tree untouched.

The block is a multi-cycle state machine. One request is taken while it is idle. It reports busy until a one-cycle completion pulse, which carries the result flags and the granted index.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole pool is one free block of order N, `busy` and `done` are low, and a first allocation of order N returns unit 0.
- R2: A successful allocation of order k returns the lowest start unit among the free blocks of the smallest free order that is at least k; the returned `grant_index` is a multiple of 2^k.
- R3: When the chosen block is larger than requested, it is halved repeatedly; the lower half is kept each time and every upper half becomes a free block that later allocations can receive.
- R4: An allocation whose order exceeds N, or for which no free block of order k or larger exists, completes with `fail` high and leaves the tree state unchanged.
- R5: Releasing a granted block of order k at unit u frees it and merges it with the buddy at unit u XOR 2^k while that buddy is free, repeating at the next order up to order N.
- R6: A release whose order exceeds N, whose unit is not a multiple of 2^order, or which names a block not currently granted at exactly that order, completes with `err` high and leaves the tree state unchanged.
- R7: `busy` is high from the cycle after a request is accepted until completion; `done` is a one-cycle pulse with `busy` low; requests presented while busy are ignored.
- R8: When `alloc_req` and `free_req` are both high in an idle cycle, only the allocation is served and the release is ignored.
- R9: `fail` and `err` are only high together with `done` and are never high at the same time; `fail` only follows allocations and `err` only follows releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocation request, sampled while idle |
| alloc_order | input | OW | Requested order (OW = clog2(N+2)) |
| free_req | input | 1 | Release request, sampled while idle |
| free_index | input | N | Start unit of the block being released |
| free_order | input | OW | Order of the block being released |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With done: allocation could not be served |
| err | output | 1 | With done: release was not valid |
| grant_index | output | N | With done after a successful allocation: start unit |

## Verification
On every cycle the assertions check the following. The done pulse is one cycle wide and never coincides with busy. The fail and err flags appear only with done and never together. A granted index is aligned to its order. No tree node is marked both free and granted. A failed search or a rejected release leaves the node state as it was. Which block the allocator picks, and how far a merge climbs, can only be shown by the bench scenarios. These drive fragmenting sequences, invalid releases, requests during busy, simultaneous requests and a long pseudo-random mix. Each result is compared against an independent model of the pool.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIND,
    ST_SPLIT,
    ST_GRANT,
    ST_FCHK,
    ST_MERGE
  } bst_e;

  // Heap numbering: root is node 1, a node at order k is 2^(levels-k) + unit/2^k.
  function automatic int node_id(int levels, int order, int unit);
    return (1 << (levels - order)) + (unit >> order);
  endfunction

  // Start unit of the other half of the same parent.
  function automatic int buddy_of(int order, int unit);
    return unit ^ (1 << order);
  endfunction

  // Start unit of the enclosing block one order up.
  function automatic int parent_of(int order, int unit);
    return unit & ~((1 << (order + 1)) - 1);
  endfunction

  function automatic bit is_aligned(int order, int unit);
    return (unit & ((1 << order) - 1)) == 0;
  endfunction

endpackage

// File: rtl/buddy_store.sv
module buddy_store #(
  parameter int NW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                free_clr_en,
  input  logic [NW-1:0]       free_clr_node,
  input  logic                free_set_en,
  input  logic [NW-1:0]       free_set_node,
  input  logic                used_set_en,
  input  logic [NW-1:0]       used_set_node,
  input  logic                used_clr_en,
  input  logic [NW-1:0]       used_clr_node,
  output logic [(1<<NW)-1:0]  free_bits,
  output logic [(1<<NW)-1:0]  used_bits
);
  localparam int NODES = 1 << NW;

  logic [NODES-1:0] free_q;
  logic [NODES-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q    <= '0;
      free_q[1] <= 1'b1;
      used_q    <= '0;
    end else begin
      if (free_clr_en) free_q[free_clr_node] <= 1'b0;
      if (free_set_en) free_q[free_set_node] <= 1'b1;
      if (used_clr_en) used_q[used_clr_node] <= 1'b0;
      if (used_set_en) used_q[used_set_node] <= 1'b1;
    end
  end

  assign free_bits = free_q;
  assign used_bits = used_q;

  // R5/R6: a node is never free and granted at once
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q & used_q) == '0);

endmodule

// File: rtl/buddy_find.sv
module buddy_find #(
  parameter int N = 4
) (
  input  logic [(1<<(N+1))-1:0] free_bits,
  output logic [N:0]            any_free,
  output logic [(N+1)*N-1:0]    low_unit
);
  for (genvar k = 0; k <= N; k++) begin : g_order
    localparam int CNT = 1 << (N - k);
    logic          any_k;
    logic [N-1:0]  unit_k;
    always_comb begin
      any_k  = 1'b0;
      unit_k = '0;
      for (int b = CNT - 1; b >= 0; b--) begin
        if (free_bits[CNT + b]) begin
          any_k  = 1'b1;
          unit_k = N'(b << k);
        end
      end
    end
    assign any_free[k]         = any_k;
    assign low_unit[k*N +: N]  = unit_k;
  end

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter int N  = 4,
  parameter int OW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic [OW-1:0] alloc_order,
  input  logic          free_req,
  input  logic [N-1:0]  free_index,
  input  logic [OW-1:0] free_order,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          err,
  output logic [N-1:0]  grant_index
);
  import buddy_pkg::*;

  localparam int NW    = N + 1;
  localparam int NODES = 1 << NW;

  bst_e          st;
  logic [OW-1:0] tgt_order;
  logic [OW-1:0] cur_order;
  logic [N-1:0]  cur_unit;
  logic          op_alloc;
  logic          done_q, fail_q, err_q;
  logic [N-1:0]  grant_q;

  logic [NODES-1:0] free_bits, used_bits;
  logic [N:0]       any_free;
  logic [(N+1)*N-1:0] low_unit;

  // store write controls
  logic          fc_en, fs_en, us_en, uc_en;
  logic [NW-1:0] fc_node, fs_node, us_node, uc_node;

  // search result
  logic          pick_ok;
  logic [OW-1:0] pick_order;
  logic [N-1:0]  pick_unit;

  // node arithmetic
  logic [NW-1:0] node_cur, node_hi, node_bud, node_req;
  logic          tgt_in_range, free_ok, merge_go;

  // named internal events
  logic ev_accept_alloc, ev_accept_free, ev_fail, ev_err, ev_split, ev_merge;

  buddy_find #(.N(N)) u_find (
    .free_bits (free_bits),
    .any_free  (any_free),
    .low_unit  (low_unit)
  );

  buddy_store #(.NW(NW)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .free_clr_en   (fc_en),
    .free_clr_node (fc_node),
    .free_set_en   (fs_en),
    .free_set_node (fs_node),
    .used_set_en   (us_en),
    .used_set_node (us_node),
    .used_clr_en   (uc_en),
    .used_clr_node (uc_node),
    .free_bits     (free_bits),
    .used_bits     (used_bits)
  );

  // smallest order >= target that has a free block; lowest unit inside it
  always_comb begin
    pick_ok    = 1'b0;
    pick_order = '0;
    pick_unit  = '0;
    for (int k = N; k >= 0; k--) begin
      if (k >= int'(tgt_order) && any_free[k]) begin
        pick_ok    = 1'b1;
        pick_order = OW'(k);
        pick_unit  = low_unit[k*N +: N];
      end
    end
  end

  assign tgt_in_range = int'(tgt_order) <= N;
  assign node_cur = NW'(node_id(N, int'(cur_order), int'(cur_unit)));
  assign node_hi  = NW'(node_id(N, int'(cur_order) - 1,
                                int'(cur_unit) + (1 << (int'(cur_order) - 1))));
  assign node_bud = NW'(node_id(N, int'(cur_order),
                                buddy_of(int'(cur_order), int'(cur_unit))));
  assign node_req = NW'(node_id(N, int'(tgt_order), int'(cur_unit)));
  assign free_ok  = tgt_in_range && is_aligned(int'(tgt_order), int'(cur_unit))
                    && used_bits[node_req];
  assign merge_go = (int'(cur_order) < N) && free_bits[node_bud];

  assign ev_accept_alloc = (st == ST_IDLE) && alloc_req;
  assign ev_accept_free  = (st == ST_IDLE) && !alloc_req && free_req;
  assign ev_fail         = (st == ST_FIND) && !pick_ok;
  assign ev_err          = (st == ST_FCHK) && !free_ok;
  assign ev_split        = (st == ST_SPLIT);
  assign ev_merge        = (st == ST_MERGE) && merge_go;

  always_comb begin
    fc_en = 1'b0; fc_node = node_cur;
    fs_en = 1'b0; fs_node = node_cur;
    us_en = 1'b0; us_node = node_cur;
    uc_en = 1'b0; uc_node = node_req;
    case (st)
      ST_SPLIT: begin
        fc_en   = 1'b1;
        fs_en   = 1'b1;
        fs_node = node_hi;
      end
      ST_GRANT: begin
        fc_en = 1'b1;
        us_en = 1'b1;
      end
      ST_FCHK: uc_en = free_ok;
      ST_MERGE: begin
        if (merge_go) begin
          fc_en   = 1'b1;
          fc_node = node_bud;
        end else begin
          fs_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tgt_order <= '0;
      cur_order <= '0;
      cur_unit  <= '0;
      op_alloc  <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      err_q     <= 1'b0;
      grant_q   <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ev_accept_alloc) begin
            tgt_order <= alloc_order;
            op_alloc  <= 1'b1;
            st        <= ST_FIND;
          end else if (ev_accept_free) begin
            tgt_order <= free_order;
            cur_unit  <= free_index;
            op_alloc  <= 1'b0;
            st        <= ST_FCHK;
          end
        end
        ST_FIND: begin
          if (!pick_ok) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cur_order <= pick_order;
            cur_unit  <= pick_unit;
            st        <= (pick_order == tgt_order) ? ST_GRANT : ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          cur_order <= cur_order - 1'b1;
          if (cur_order - 1'b1 == tgt_order) st <= ST_GRANT;
        end
        ST_GRANT: begin
          grant_q <= cur_unit;
          done_q  <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_FCHK: begin
          if (!free_ok) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cur_order <= tgt_order;
            st        <= ST_MERGE;
          end
        end
        ST_MERGE: begin
          if (merge_go) begin
            cur_unit  <= N'(parent_of(int'(cur_order), int'(cur_unit)));
            cur_order <= cur_order + 1'b1;
          end else begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign done        = done_q;
  assign fail        = fail_q;
  assign err         = err_q;
  assign grant_index = grant_q;

  // R7: completion is a single-cycle pulse, never while busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: flags only with done, never together, each tied to its operation
  p_flags_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail || err) |-> done);
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail && err));
  p_fail_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> op_alloc);
  // R2: granted start unit is aligned to the requested order
  p_grant_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_alloc && !fail) |->
      is_aligned(int'(tgt_order), int'(grant_index)));
  // R4: a failed search does not touch the tree
  p_fail_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> ($stable(free_bits) && $stable(used_bits)));
  // R6: a rejected release does not touch the tree
  p_err_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> ($stable(free_bits) && $stable(used_bits)));
  // R3: each split step consumes one free node and produces one
  p_split_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_split && free_bits[node_cur]) |=>
      ($countones(free_bits) == $past($countones(free_bits))));

endmodule

// File: tb/buddy_alloc_bench.sv
module buddy_alloc_bench;
  localparam int N    = 4;
  localparam int OW   = $clog2(N + 2);
  localparam int UNITS = 1 << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic [OW-1:0] alloc_order = '0;
  logic          free_req = 1'b0;
  logic [N-1:0]  free_index = '0;
  logic [OW-1:0] free_order = '0;
  logic          busy, done, fail, err;
  logic [N-1:0]  grant_index;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  buddy_alloc #(.N(N)) u_buddy_alloc (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_order(alloc_order),
    .free_req(free_req), .free_index(free_index), .free_order(free_order),
    .busy(busy), .done(done), .fail(fail), .err(err),
    .grant_index(grant_index)
  );

  // ---------------- reference pool model (indexed by order, start unit)
  bit mfree [0:N][0:UNITS-1];
  bit mused [0:N][0:UNITS-1];

  task automatic m_reset();
    for (int k = 0; k <= N; k++)
      for (int u = 0; u < UNITS; u++) begin
        mfree[k][u] = 1'b0;
        mused[k][u] = 1'b0;
      end
    mfree[N][0] = 1'b1;
  endtask

  task automatic m_alloc(input int o, output bit ok, output int unit);
    int k;
    ok = 1'b0; unit = -1; k = -1;
    if (o <= N) begin
      for (int kk = o; kk <= N && !ok; kk++)
        for (int u = 0; u < UNITS && !ok; u += (1 << kk))
          if (mfree[kk][u]) begin ok = 1'b1; unit = u; k = kk; end
    end
    if (ok) begin
      mfree[k][unit] = 1'b0;
      while (k > o) begin
        k--;
        mfree[k][unit + (1 << k)] = 1'b1;
      end
      mused[o][unit] = 1'b1;
    end
  endtask

  task automatic m_free(input int o, input int u, output bit ok);
    int k, x;
    ok = (o <= N) && (u % (1 << o) == 0) && mused[o][u];
    if (ok) begin
      mused[o][u] = 1'b0;
      k = o; x = u;
      while (k < N && mfree[k][x ^ (1 << k)]) begin
        mfree[k][x ^ (1 << k)] = 1'b0;
        x = x & ~((1 << (k + 1)) - 1);
        k++;
      end
      mfree[k][x] = 1'b1;
    end
  endtask

  // ---------------- scoreboard
  typedef struct {
    bit    is_alloc;
    bit    exp_fail;
    bit    exp_err;
    int    exp_unit;
    string tag;
  } exp_t;
  exp_t sq[$];

  task automatic check(input bit cond, input string tag, input int act, input int expv);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops one expectation per completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sq.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sq.pop_front();
        if (e.is_alloc) begin
          check(fail == e.exp_fail && err == 1'b0, {e.tag, " fail flag"},
                int'(fail), int'(e.exp_fail));
          if (!e.exp_fail)
            check(int'(grant_index) == e.exp_unit, {e.tag, " grant_index"},
                  int'(grant_index), e.exp_unit);
        end else begin
          check(err == e.exp_err && fail == 1'b0, {e.tag, " err flag"},
                int'(err), int'(e.exp_err));
        end
        check(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
      end
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  // hand: -2 use model only, -1 expect fail, >=0 expected unit
  task automatic do_alloc(input int o, input string tag, input int hand);
    exp_t e; bit ok; int u;
    m_alloc(o, ok, u);
    e.is_alloc = 1'b1;
    e.exp_fail = (hand == -2) ? !ok : (hand == -1);
    e.exp_unit = (hand == -2) ? u : hand;
    e.exp_err  = 1'b0;
    e.tag      = tag;
    if (hand != -2) check((ok ? u : -1) == hand, {tag, " model"}, ok ? u : -1, hand);
    sq.push_back(e);
    @(negedge clk);
    alloc_req = 1'b1; alloc_order = OW'(o);
    @(negedge clk);
    alloc_req = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    while (!done) @(negedge clk);
  endtask

  // hand: -2 use model only, 0 expect accepted, 1 expect err
  task automatic do_free(input int o, input int u, input string tag, input int hand);
    exp_t e; bit ok;
    m_free(o, u, ok);
    e.is_alloc = 1'b0;
    e.exp_err  = (hand == -2) ? !ok : (hand == 1);
    e.exp_fail = 1'b0;
    e.exp_unit = 0;
    e.tag      = tag;
    sq.push_back(e);
    @(negedge clk);
    free_req = 1'b1; free_order = OW'(o); free_index = N'(u);
    @(negedge clk);
    free_req = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    while (!done) @(negedge clk);
  endtask

  int al_o[$];
  int al_u[$];
  int lcg = 32'h1234_5678;

  function automatic int rnd(int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7fff_ffff) % m;
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    check(done == 1'b0, "R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: whole pool free
    do_alloc(4, "R1 whole pool", 0);
    do_alloc(0, "R4 pool exhausted", -1);
    do_free(4, 0, "R5 free whole", 0);

    // R2/R3: successive splits hand out lower halves, upper halves remain
    do_alloc(0, "R2 first unit", 0);
    do_alloc(0, "R3 upper half of split", 1);
    do_alloc(1, "R3 order1 remnant", 2);
    do_alloc(2, "R3 order2 remnant", 4);
    do_alloc(3, "R3 order3 remnant", 8);
    do_alloc(0, "R4 no block left", -1);

    // R5: merging climbs until a busy buddy
    do_free(0, 0, "R5 free unit0", 0);
    do_alloc(1, "R5 no merge while buddy busy", -1);
    do_free(0, 1, "R5 merge to order1", 0);
    do_alloc(1, "R5 merged block reusable", 0);
    do_free(1, 0, "R5 free order1", 0);
    do_free(1, 2, "R5 merge to order2", 0);
    do_free(2, 4, "R5 merge to order3", 0);
    do_free(3, 8, "R5 merge to root", 0);
    do_alloc(4, "R5 root restored", 0);
    do_free(4, 0, "R5 free root", 0);

    // R6: invalid releases rejected, state kept
    do_free(0, 3, "R6 not granted", 1);
    do_alloc(2, "R2 order2 at 0", 0);
    do_free(1, 0, "R6 wrong order", 1);
    do_free(2, 2, "R6 misaligned", 1);
    do_free(7, 0, "R6 order out of range", 1);
    do_alloc(7, "R4 order out of range", -1);
    do_alloc(2, "R6 state unchanged", 4);
    do_free(2, 4, "R5 free order2 at 4", 0);

    // R2: lowest start unit among smallest sufficient order
    do_alloc(3, "R2 order3 upper", 8);
    do_free(2, 0, "R5 free order2 at 0", 0);
    do_alloc(1, "R2 smallest sufficient", 0);

    // R7: request during busy ignored (block 8 order3 stays granted)
    begin
      exp_t e; bit ok; int u;
      m_alloc(0, ok, u);
      e.is_alloc = 1'b1; e.exp_fail = !ok; e.exp_unit = u; e.exp_err = 1'b0;
      e.tag = "R7 alloc with ignored free";
      check(ok && u == 2, "R7 model", u, 2);
      sq.push_back(e);
      @(negedge clk);
      alloc_req = 1'b1; alloc_order = OW'(0);
      @(negedge clk);
      alloc_req = 1'b0;
      free_req = 1'b1; free_order = OW'(3); free_index = N'(8);
      @(negedge clk);
      free_req = 1'b0;
      while (!done) @(negedge clk);
    end
    do_free(3, 8, "R7 block still granted", 0);

    // R8: simultaneous requests: alloc served, free ignored
    begin
      exp_t e; bit ok; int u;
      m_alloc(1, ok, u);
      e.is_alloc = 1'b1; e.exp_fail = !ok; e.exp_unit = u; e.exp_err = 1'b0;
      e.tag = "R8 simultaneous alloc";
      sq.push_back(e);
      @(negedge clk);
      alloc_req = 1'b1; alloc_order = OW'(1);
      free_req = 1'b1; free_order = OW'(1); free_index = N'(0);
      @(negedge clk);
      alloc_req = 1'b0; free_req = 1'b0;
      while (!done) @(negedge clk);
    end
    do_free(1, 0, "R8 ignored free left block granted", 0);

    // drain the directed leftovers using the model
    for (int o = 0; o <= N; o++)
      for (int u = 0; u < UNITS; u++)
        if (mused[o][u]) do_free(o, u, "R5 drain", 0);
    do_alloc(4, "R5 drained pool whole", 0);
    do_free(4, 0, "R5 free root again", 0);

    // R2-R6 mixed pseudo-random traffic against the model
    for (int i = 0; i < 120; i++) begin
      if (al_o.size() > 0 && rnd(3) == 0) begin
        int j;
        j = rnd(al_o.size());
        do_free(al_o[j], al_u[j], "R5 random free", -2);
        al_o.delete(j); al_u.delete(j);
      end else if (rnd(8) == 0) begin
        do_free(rnd(N + 1), rnd(UNITS), "R6 random free", -2);
        for (int j = al_o.size() - 1; j >= 0; j--)
          if (!mused[al_o[j]][al_u[j]]) begin al_o.delete(j); al_u.delete(j); end
      end else begin
        int o; bit ok_before;
        o = rnd(N + 1);
        do_alloc(o, "R2 random alloc", -2);
        ok_before = 1'b0;
        for (int u = 0; u < UNITS; u += (1 << o))
          if (mused[o][u]) begin
            ok_before = 1'b0;
            for (int j = 0; j < al_o.size(); j++)
              if (al_o[j] == o && al_u[j] == u) ok_before = 1'b1;
            if (!ok_before) begin al_o.push_back(o); al_u.push_back(u); end
          end
      end
    end

    repeat (3) @(negedge clk);
    check(sq.size() == 0, "R7 all results seen", sq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule